// File: doc/BRIEF.md
# Extended-Width Memory Transfer Path

This block sits between a bank of 16-bit core registers and a unified data memory in which some address regions hold 24-bit words and others hold 16-bit words. It formats register data for memory writes and extracts register data from memory reads. An 8-bit side register supplies or absorbs the low byte of 24-bit words. The access type (plain 16-bit, 24-bit, or 24-bit with an immediate low byte) comes from the instruction. The region width comes from the address, so it is only known at run time. The block defines what happens when the two do not match.

The memory bus is 24 bits wide and left-aligned. A 24-bit region uses all of it. A 16-bit region presents its word on bits 23:8, and whatever sits on bits 7:0 is passed through as-is. Register data is always right-justified. A width code selects the valid width for short registers: 16, 9, 8 or 4 bits. The core can read the side register at any time and can load it directly.

Top module: `xw_xfer_path`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the side register output `ext_q` reads 0x00.
- R2: On a 24-bit read (`xfer_kind`=1, `xfer_write`=0, `xfer_valid`=1), `reg_rdata` equals `mem_rdata[23:8]` in the same cycle, and `ext_q` holds `mem_rdata[7:0]` from the next cycle on.
- R3: A 24-bit read of a 16-bit region (`wide_region`=0) still loads `ext_q` with whatever `mem_rdata[7:0]` carried, including 0x00.
- R4: A 16-bit read (`xfer_kind`=0) returns `mem_rdata[23:8]` and leaves `ext_q` unchanged.
- R5: A 24-bit write (`xfer_kind`=1) to a 24-bit region drives `mem_wdata` = {source, `ext_q`}.
- R6: A 24-bit immediate write (`xfer_kind`=2) to a 24-bit region drives `mem_wdata` = {source, `imm_low`}, whatever `ext_q` holds.
- R7: A 16-bit write (`xfer_kind`=0) drives `mem_wdata` = {source, 8'h00}.
- R8: Any write to a 16-bit region drives `mem_wdata[7:0]` = 0x00. The side register content is discarded and `ext_q` does not change.
- R9: Read data is masked by `width_sel`: code 0 keeps 16 bits, 1 keeps 9, 2 keeps 8 and 3 keeps 4. The dropped high bits of `reg_rdata` read zero.
- R10: Source data is masked by `width_sel` with the same codes before it is placed on `mem_wdata[23:8]`. The missing high bits are written as zero.
- R11: A core load (`ext_wr`=1) sets `ext_q` to `ext_wdata` on the next cycle. When a 24-bit read happens in the same cycle, the memory low byte wins.
- R12: `mem_we` is high exactly when `xfer_valid` and `xfer_write` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | A memory transfer happens this cycle |
| xfer_write | input | 1 | 1 = write to memory, 0 = read |
| xfer_kind | input | 2 | 0 = 16-bit, 1 = 24-bit, 2 = 24-bit immediate, 3 = treated as 16-bit |
| wide_region | input | 1 | Addressed region holds 24-bit words |
| width_sel | input | 2 | Register width code: 0=16, 1=9, 2=8, 3=4 bits |
| reg_wdata | input | 16 | Source register data |
| imm_low | input | 8 | Immediate low byte for kind 2 writes |
| mem_rdata | input | 24 | Data returned by memory |
| ext_wr | input | 1 | Core load of the side register |
| ext_wdata | input | 8 | Value for the core load |
| mem_wdata | output | 24 | Data driven to memory |
| mem_we | output | 1 | Memory write strobe |
| reg_rdata | output | 16 | Destination register data |
| ext_q | output | 8 | Current side register content |

## Verification
The assertions check the following on every cycle:
- low-byte zeroing for 16-bit writes and for writes to 16-bit regions;
- the side-register byte on wide 24-bit writes;
- the write strobe;
- masking of 4-bit reads;
- the next-cycle behaviour of the side register: fill, core load, priority and hold.

Only the bench scenarios show full data values end to end:
- a fill followed by a write that reuses the filled byte;
- an immediate byte overriding a non-zero side register;
- a fill from a 16-bit region that returns a non-zero low byte;
- the 9- and 8-bit masks on both directions.

// File: rtl/xw_pkg.sv
package xw_pkg;
   typedef enum logic [1:0] {
      XK_SHORT    = 2'd0,
      XK_WIDE     = 2'd1,
      XK_WIDE_IMM = 2'd2,
      XK_RSVD     = 2'd3
   } xfer_kind_e;

   typedef enum logic [1:0] {
      WS_FULL  = 2'd0,
      WS_MID   = 2'd1,
      WS_BYTE  = 2'd2,
      WS_NIB   = 2'd3
   } width_sel_e;
endpackage

// File: rtl/xw_narrow.sv
module xw_narrow #(
   parameter int W  = 16,
   parameter int NA = 9,
   parameter int NB = 8,
   parameter int NC = 4
) (
   input  logic [W-1:0] din,
   input  logic [1:0]   sel,
   output logic [W-1:0] dout
);
   import xw_pkg::*;

   logic [W-1:0] m_a, m_b, m_c;

   for (genvar i = 0; i < W; i++) begin : g_mask
      assign m_a[i] = (i < NA);
      assign m_b[i] = (i < NB);
      assign m_c[i] = (i < NC);
   end

   always_comb begin
      case (width_sel_e'(sel))
         WS_MID:  dout = din & m_a;
         WS_BYTE: dout = din & m_b;
         WS_NIB:  dout = din & m_c;
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/xw_pack.sv
module xw_pack #(
   parameter int REG_W = 16,
   parameter int EXT_W = 8
) (
   input  logic [1:0]             kind,
   input  logic                   wide,
   input  logic [REG_W-1:0]       src,
   input  logic [EXT_W-1:0]       ext,
   input  logic [EXT_W-1:0]       imm,
   output logic [REG_W+EXT_W-1:0] word
);
   import xw_pkg::*;

   logic [EXT_W-1:0] low;

   always_comb begin
      low = '0;
      if (wide) begin
         case (xfer_kind_e'(kind))
            XK_WIDE:     low = ext;
            XK_WIDE_IMM: low = imm;
            default:     low = '0;
         endcase
      end
      word = {src, low};
   end
endmodule

// File: rtl/xw_ext_reg.sv
module xw_ext_reg #(
   parameter int EXT_W     = 8,
   parameter bit FILL_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [EXT_W-1:0] fill_d,
   input  logic             core_we,
   input  logic [EXT_W-1:0] core_d,
   output logic [EXT_W-1:0] q
);
   logic [EXT_W-1:0] nxt;

   if (FILL_WINS) begin : g_fill_first
      always_comb begin
         if (fill_en)      nxt = fill_d;
         else if (core_we) nxt = core_d;
         else              nxt = q;
      end
   end else begin : g_core_first
      always_comb begin
         if (core_we)      nxt = core_d;
         else if (fill_en) nxt = fill_d;
         else              nxt = q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/xw_xfer_path.sv
module xw_xfer_path #(
   parameter int REG_W     = 16,
   parameter int EXT_W     = 8,
   parameter int NARROW_A  = 9,
   parameter int NARROW_B  = 8,
   parameter int NARROW_C  = 4,
   parameter bit FILL_WINS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   xfer_valid,
   input  logic                   xfer_write,
   input  logic [1:0]             xfer_kind,
   input  logic                   wide_region,
   input  logic [1:0]             width_sel,
   input  logic [REG_W-1:0]       reg_wdata,
   input  logic [EXT_W-1:0]       imm_low,
   input  logic [REG_W+EXT_W-1:0] mem_rdata,
   input  logic                   ext_wr,
   input  logic [EXT_W-1:0]       ext_wdata,
   output logic [REG_W+EXT_W-1:0] mem_wdata,
   output logic                   mem_we,
   output logic [REG_W-1:0]       reg_rdata,
   output logic [EXT_W-1:0]       ext_q
);
   import xw_pkg::*;

   localparam int MEM_W = REG_W + EXT_W;

   if (NARROW_A > REG_W || NARROW_B > REG_W || NARROW_C > REG_W) begin : g_bad_narrow
      $error("narrow widths must not exceed REG_W");
   end
   if (NARROW_C < 1 || EXT_W < 1) begin : g_bad_min
      $error("widths must be at least one bit");
   end

   logic [REG_W-1:0] rd_hi, src_cut;
   logic             fill_en;

   assign rd_hi   = mem_rdata[MEM_W-1 -: REG_W];
   assign fill_en = xfer_valid && !xfer_write && (xfer_kind_e'(xfer_kind) == XK_WIDE);
   assign mem_we  = xfer_valid && xfer_write;

   xw_narrow #(.W(REG_W), .NA(NARROW_A), .NB(NARROW_B), .NC(NARROW_C)) rd_cut_i (
      .din (rd_hi),
      .sel (width_sel),
      .dout(reg_rdata)
   );

   xw_narrow #(.W(REG_W), .NA(NARROW_A), .NB(NARROW_B), .NC(NARROW_C)) wr_cut_i (
      .din (reg_wdata),
      .sel (width_sel),
      .dout(src_cut)
   );

   xw_pack #(.REG_W(REG_W), .EXT_W(EXT_W)) pack_i (
      .kind(xfer_kind),
      .wide(wide_region),
      .src (src_cut),
      .ext (ext_q),
      .imm (imm_low),
      .word(mem_wdata)
   );

   xw_ext_reg #(.EXT_W(EXT_W), .FILL_WINS(FILL_WINS)) ext_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill_en(fill_en),
      .fill_d (mem_rdata[EXT_W-1:0]),
      .core_we(ext_wr),
      .core_d (ext_wdata),
      .q      (ext_q)
   );
endmodule

// File: rtl/xw_xfer_path_chk.sv
module xw_xfer_path_chk #(
   parameter int REG_W     = 16,
   parameter int EXT_W     = 8,
   parameter int NARROW_C  = 4,
   parameter bit FILL_WINS = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   xfer_valid,
   input logic                   xfer_write,
   input logic [1:0]             xfer_kind,
   input logic                   wide_region,
   input logic [1:0]             width_sel,
   input logic [REG_W-1:0]       reg_wdata,
   input logic [EXT_W-1:0]       imm_low,
   input logic [REG_W+EXT_W-1:0] mem_rdata,
   input logic                   ext_wr,
   input logic [EXT_W-1:0]       ext_wdata,
   input logic [REG_W+EXT_W-1:0] mem_wdata,
   input logic                   mem_we,
   input logic [REG_W-1:0]       reg_rdata,
   input logic [EXT_W-1:0]       ext_q
);
   logic fill;
   assign fill = xfer_valid && !xfer_write && (xfer_kind == 2'd1);

   AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && (FILL_WINS || !ext_wr)) |=> ext_q == $past(mem_rdata[EXT_W-1:0]));  // R11
   AST_CORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && !fill) |=> ext_q == $past(ext_wdata));  // R11
   AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill && !ext_wr) |=> $stable(ext_q));  // R4
   AST_NARROW_REGION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_write && !wide_region) |-> mem_wdata[EXT_W-1:0] == '0);  // R8
   AST_SHORT_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_write && xfer_kind == 2'd0) |-> mem_wdata[EXT_W-1:0] == '0);  // R7
   AST_WIDE_USES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_write && wide_region && xfer_kind == 2'd1)
      |-> mem_wdata[EXT_W-1:0] == ext_q);  // R5
   AST_NIB_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (width_sel == 2'd3) |-> reg_rdata[REG_W-1:NARROW_C] == '0);  // R9
   AST_NO_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_valid || !xfer_write) |-> !mem_we);  // R12
endmodule

bind xw_xfer_path xw_xfer_path_chk #(
   .REG_W(REG_W), .EXT_W(EXT_W), .NARROW_C(NARROW_C), .FILL_WINS(FILL_WINS)
) chk_i (.*);

// File: tb/xw_xfer_path_tb_top.sv
module xw_xfer_path_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_valid = 1'b0, xfer_write = 1'b0, wide_region = 1'b0, ext_wr = 1'b0;
   logic [1:0]  xfer_kind = 2'd0, width_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [7:0]  imm_low = '0, ext_wdata = '0;
   logic [23:0] mem_rdata = '0;
   logic [23:0] mem_wdata;
   logic        mem_we;
   logic [15:0] reg_rdata;
   logic [7:0]  ext_q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [23:0] wd;
      logic        we;
      logic [15:0] rd;
      logic [7:0]  ext;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [7:0]  model_ext = 8'h00;

   always #10 clk = ~clk;

   xw_xfer_path dut_i (
      .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
      .xfer_kind(xfer_kind), .wide_region(wide_region), .width_sel(width_sel),
      .reg_wdata(reg_wdata), .imm_low(imm_low), .mem_rdata(mem_rdata),
      .ext_wr(ext_wr), .ext_wdata(ext_wdata), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .reg_rdata(reg_rdata), .ext_q(ext_q)
   );

   function automatic logic [15:0] mask_of(input logic [1:0] ws);
      case (ws)
         2'd1:    return 16'h01FF;
         2'd2:    return 16'h00FF;
         2'd3:    return 16'h000F;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [23:0] act,
                        input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic do_op(input logic v, input logic wr, input logic [1:0] k,
                        input logic wide, input logic [1:0] ws, input logic [15:0] src,
                        input logic [7:0] imm, input logic [23:0] mrd,
                        input logic ew, input logic [7:0] ed, input string tag);
      exp_t e;
      logic [15:0] s;
      @(posedge clk);
      #2;
      xfer_valid = v; xfer_write = wr; xfer_kind = k; wide_region = wide;
      width_sel = ws; reg_wdata = src; imm_low = imm; mem_rdata = mrd;
      ext_wr = ew; ext_wdata = ed;
      s = src & mask_of(ws);
      if (wide && k == 2'd1)      e.wd = {s, model_ext};
      else if (wide && k == 2'd2) e.wd = {s, imm};
      else                        e.wd = {s, 8'h00};
      e.we  = v && wr;
      e.rd  = mrd[23:8] & mask_of(ws);
      e.ext = model_ext;
      e.tag = tag;
      sb.push_back(e);
      if (v && !wr && k == 2'd1) model_ext = mrd[7:0];
      else if (ew)               model_ext = ed;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, "mem_wdata", mem_wdata, e.wd);
            check(e.tag, "mem_we", {23'd0, mem_we}, {23'd0, e.we});
            check(e.tag, "reg_rdata", {8'd0, reg_rdata}, {8'd0, e.rd});
            check(e.tag, "ext_q", {16'd0, ext_q}, {16'd0, e.ext});
         end
      end
   end

   initial begin : watchdog
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      check("R1", "ext_q in reset", {16'd0, ext_q}, 24'h0);
      @(posedge clk); #2; rst_n = 1'b1;
      // R1: first cycle after reset, then R11 core load
      do_op(0, 0, 2'd0, 1, 2'd0, 16'h0, 8'h0, 24'h0, 1, 8'h5A, "R1");
      do_op(1, 1, 2'd1, 1, 2'd0, 16'h1234, 8'h00, 24'h0, 0, 8'h0, "R11_R5");
      do_op(1, 1, 2'd2, 1, 2'd0, 16'hBEEF, 8'hC3, 24'h0, 0, 8'h0, "R6");
      do_op(1, 1, 2'd0, 1, 2'd0, 16'h1357, 8'hC3, 24'h0, 0, 8'h0, "R7");
      do_op(1, 1, 2'd1, 0, 2'd0, 16'hABCD, 8'h00, 24'h0, 0, 8'h0, "R8");
      do_op(1, 1, 2'd2, 0, 2'd0, 16'h2222, 8'h77, 24'h0, 0, 8'h0, "R8");
      do_op(1, 0, 2'd1, 1, 2'd0, 16'h0, 8'h0, 24'h9876A5, 0, 8'h0, "R2");
      do_op(1, 1, 2'd1, 1, 2'd0, 16'h0F0F, 8'h0, 24'h0, 0, 8'h0, "R2_R5");
      do_op(1, 0, 2'd0, 1, 2'd0, 16'h0, 8'h0, 24'h4321FF, 0, 8'h0, "R4");
      do_op(1, 0, 2'd1, 0, 2'd0, 16'h0, 8'h0, 24'h246800, 0, 8'h0, "R3");
      do_op(1, 0, 2'd1, 0, 2'd0, 16'h0, 8'h0, 24'h11223C, 0, 8'h0, "R3");
      do_op(1, 0, 2'd0, 1, 2'd1, 16'h0, 8'h0, 24'hFFFF77, 0, 8'h0, "R9");
      do_op(1, 0, 2'd0, 1, 2'd2, 16'h0, 8'h0, 24'hFFFF77, 0, 8'h0, "R9");
      do_op(1, 0, 2'd0, 1, 2'd3, 16'h0, 8'h0, 24'hFFFF77, 0, 8'h0, "R9");
      do_op(1, 1, 2'd0, 1, 2'd3, 16'hFFFF, 8'h0, 24'h0, 0, 8'h0, "R10");
      do_op(1, 1, 2'd1, 1, 2'd1, 16'hFFFF, 8'h0, 24'h0, 0, 8'h0, "R10");
      do_op(1, 1, 2'd2, 1, 2'd2, 16'hA5A5, 8'h11, 24'h0, 0, 8'h0, "R10");
      do_op(1, 0, 2'd1, 1, 2'd0, 16'h0, 8'h0, 24'h000066, 1, 8'h99, "R11");
      do_op(0, 0, 2'd0, 1, 2'd0, 16'h0, 8'h0, 24'h0, 1, 8'hE1, "R11");
      do_op(0, 1, 2'd1, 1, 2'd0, 16'h5555, 8'h0, 24'h0, 0, 8'h0, "R12");
      do_op(1, 0, 2'd2, 1, 2'd0, 16'h5555, 8'h0, 24'hCAFE42, 0, 8'h0, "R12_R4");
      do_op(0, 0, 2'd0, 1, 2'd0, 16'h0, 8'h0, 24'h0, 0, 8'h0, "R4");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule